// File: doc/BRIEF.md
# Vector-Indexed Address Generator

This block turns one indexed vector memory request into a stream of effective addresses. A start pulse captures a scalar base address, a 512-bit index vector, a two-bit scale code, a signed displacement, a lane mask, a mode bit and a format bit. The mode bit selects how the index vector is split. It is either sixteen signed 32-bit indexes or eight signed 64-bit indexes.

The block then visits the active lanes, starting at lane 0 and moving upward. For each active lane it forms base + (index << scale) + displacement and presents the result on a valid/ready output with the lane number and the format tag. It accepts at most one beat per cycle. After the last beat is accepted, it raises a one-cycle done pulse. The memory operations that consume these addresses live downstream and are not part of this block.

Top module: `vidx_agen`

## Requirements
- R1: After reset, out_valid, busy and done are all 0.
- R2: With wide_idx = 0 at start, lane i (0..15) uses bits [32i+31:32i] of idx_vec as a signed index, sign-extended to 64 bits.
- R3: With wide_idx = 1 at start, lane i (0..7) uses bits [64i+63:64i] of idx_vec as a signed 64-bit index. Mask bits 15:8 are ignored.
- R4: Each beat's out_addr is base_addr + (index << scale_sel) + sign-extended disp, modulo 2^64. The scale_sel values 0, 1, 2 and 3 mean 1, 2, 4 and 8.
- R5: Each lane whose lane_mask bit is 1 gives exactly one beat, in ascending lane order, with its number on out_lane. Lanes whose mask bit is 0 give no beat.
- R6: While out_valid is 1 and out_ready is 0, out_addr, out_lane and out_fp64 hold steady. The stream advances by one beat on each cycle where both are 1.
- R7: done is 1 for exactly one cycle. That cycle follows the acceptance of the last beat. If the effective mask is empty, it follows the start cycle instead.
- R8: busy is 1 from the cycle after an accepted start until the last beat is accepted. A start pulse while busy is ignored and does not change the beats.
- R9: out_fp64 carries the elem_fp64 value captured at start. Input changes after the start cycle do not affect any beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures all request inputs when the block is idle |
| base_addr | input | 64 | Scalar base address |
| idx_vec | input | 512 | Index vector |
| scale_sel | input | 2 | Scale code: index is shifted left by this amount |
| disp | input | 32 | Signed displacement |
| lane_mask | input | 16 | Lane enables, bit i for lane i |
| wide_idx | input | 1 | 0: sixteen 32-bit indexes, 1: eight 64-bit indexes |
| elem_fp64 | input | 1 | Element format tag passed to every beat |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | 64 | Effective address |
| out_lane | output | 4 | Lane number of the beat |
| out_fp64 | output | 1 | Format tag of the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Requests are run with these patterns:
- Small positive indexes with a full mask and unit scale confirm the basic lane split.
- Negative 32-bit indexes with the largest scale and a negative displacement separate correct sign extension from zero extension.
- Large 64-bit indexes that overflow the address sum separate the two modes and check wraparound. In the same run, upper mask bits set in wide mode must produce no beats.
- Empty masks, a single top lane, a consumer that stalls at random, a second start during a sequence, and inputs scrambled right after start check the lane order, beat holding, done timing and input capture.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
  localparam int VA_AW = 64;
  localparam int VA_VW = 512;
  localparam int VA_NL = VA_VW / 32;
  localparam int VA_NW = VA_VW / 64;
  localparam int VA_LW = $clog2(VA_NL);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} agen_state_e;

  function automatic logic [VA_AW-1:0] ea_sum(
    input logic [VA_AW-1:0] base,
    input logic [VA_AW-1:0] idx,
    input logic [1:0]       scale,
    input logic [VA_AW-1:0] disp_sx
  );
    return base + (idx << scale) + disp_sx;
  endfunction
endpackage

// File: rtl/idx_lane_sel.sv
module idx_lane_sel
  import vagen_pkg::*;
(
  input  logic [VA_VW-1:0] vec,
  input  logic [VA_LW-1:0] lane,
  input  logic             wide,
  output logic [VA_AW-1:0] idx
);
  logic [VA_AW-1:0] narrow_ix [VA_NL];
  logic [VA_AW-1:0] wide_ix   [VA_NW];

  for (genvar g = 0; g < VA_NL; g++) begin : g_narrow
    assign narrow_ix[g] = {{(VA_AW-32){vec[32*g+31]}}, vec[32*g +: 32]};
  end
  for (genvar g = 0; g < VA_NW; g++) begin : g_wide
    assign wide_ix[g] = vec[64*g +: 64];
  end

  assign idx = wide ? wide_ix[lane[VA_LW-2:0]] : narrow_ix[lane];
endmodule

// File: rtl/lane_pick.sv
module lane_pick
  import vagen_pkg::*;
(
  input  logic [VA_NL-1:0] pend,
  output logic             any,
  output logic [VA_LW-1:0] first
);
  always_comb begin
    first = '0;
    for (int i = VA_NL - 1; i >= 0; i--) begin
      if (pend[i]) first = VA_LW'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import vagen_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic [VA_AW-1:0]  base,
  input  logic [VA_AW-1:0]  idx,
  input  logic [1:0]        scale,
  input  logic [DISP_W-1:0] disp,
  output logic [VA_AW-1:0]  ea
);
  logic [VA_AW-1:0] disp_sx;
  assign disp_sx = {{(VA_AW-DISP_W){disp[DISP_W-1]}}, disp};
  assign ea      = ea_sum(base, idx, scale, disp_sx);
endmodule

// File: rtl/vidx_agen.sv
module vidx_agen
  import vagen_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_AW-1:0]  base_addr,
  input  logic [VA_VW-1:0]  idx_vec,
  input  logic [1:0]        scale_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [VA_NL-1:0]  lane_mask,
  input  logic              wide_idx,
  input  logic              elem_fp64,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VA_AW-1:0]  out_addr,
  output logic [VA_LW-1:0]  out_lane,
  output logic              out_fp64,
  output logic              busy,
  output logic              done
);
  localparam logic [VA_NL-1:0] LOW_HALF = {{(VA_NL-VA_NW){1'b0}}, {VA_NW{1'b1}}};

  agen_state_e        state_q;
  logic [VA_AW-1:0]   base_q;
  logic [VA_VW-1:0]   vec_q;
  logic [1:0]         scale_q;
  logic [DISP_W-1:0]  disp_q;
  logic               wide_q;
  logic               fp_q;
  logic [VA_NL-1:0]   pend_q;
  logic               done_q;

  // named events for the checker
  logic               launch;
  logic               beat_take;
  logic [VA_NL-1:0]   eff_mask;
  logic [VA_NL-1:0]   pend_next;
  logic               any_pend;
  logic [VA_LW-1:0]   cur_lane;
  logic [VA_AW-1:0]   cur_idx;

  assign eff_mask  = wide_idx ? (lane_mask & LOW_HALF) : lane_mask;
  assign launch    = start && (state_q == ST_IDLE);
  assign beat_take = out_valid && out_ready;
  assign pend_next = pend_q & ~(VA_NL'(1) << cur_lane);

  lane_pick u_pick (
    .pend  (pend_q),
    .any   (any_pend),
    .first (cur_lane)
  );

  idx_lane_sel u_sel (
    .vec  (vec_q),
    .lane (cur_lane),
    .wide (wide_q),
    .idx  (cur_idx)
  );

  ea_adder #(.DISP_W(DISP_W)) u_add (
    .base  (base_q),
    .idx   (cur_idx),
    .scale (scale_q),
    .disp  (disp_q),
    .ea    (out_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      vec_q   <= '0;
      scale_q <= '0;
      disp_q  <= '0;
      wide_q  <= 1'b0;
      fp_q    <= 1'b0;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            base_q  <= base_addr;
            vec_q   <= idx_vec;
            scale_q <= scale_sel;
            disp_q  <= disp;
            wide_q  <= wide_idx;
            fp_q    <= elem_fp64;
            pend_q  <= eff_mask;
            if (eff_mask == '0) done_q  <= 1'b1;
            else                state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (beat_take) begin
            pend_q <= pend_next;
            if (pend_next == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state_q == ST_RUN) && any_pend;
  assign out_lane  = cur_lane;
  assign out_fp64  = fp_q;
  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;
endmodule

// File: rtl/vidx_agen_chk.sv
module vidx_agen_chk
  import vagen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VA_AW-1:0] out_addr,
  input logic [VA_LW-1:0] out_lane,
  input logic             out_fp64,
  input logic             busy,
  input logic             done,
  input logic             wide_q,
  input logic [VA_NL-1:0] pend_q
);
  // R6: a stalled beat holds its contents
  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_lane) && $stable(out_fp64));

  // R5: lanes only move upward within a sequence
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (out_lane > $past(out_lane)));

  // R5: an accepted lane is retired
  a_r5_lane_retired: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !pend_q[$past(out_lane)]);

  // R7: done lasts one cycle and never overlaps a beat
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !busy);

  // R3: wide mode only issues lanes 0..7
  a_r3_wide_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wide_q |-> out_lane < VA_LW'(VA_NW));

  // R8: start while busy keeps the sequence running
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_valid && out_ready) |=> busy && $stable(pend_q));
endmodule

bind vidx_agen vidx_agen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_lane  (out_lane),
  .out_fp64  (out_fp64),
  .busy      (busy),
  .done      (done),
  .wide_q    (wide_q),
  .pend_q    (pend_q)
);

// File: tb/sim_vidx_agen.sv
module sim_vidx_agen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] addr;
    logic [3:0]  lane;
    logic        fp;
  } beat_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  base_addr = '0;
  logic [511:0] idx_vec = '0;
  logic [1:0]   scale_sel = '0;
  logic [31:0]  disp = '0;
  logic [15:0]  lane_mask = '0;
  logic         wide_idx = 1'b0;
  logic         elem_fp64 = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [63:0]  out_addr;
  logic [3:0]   out_lane;
  logic         out_fp64;
  logic         busy;
  logic         done;

  int    checks = 0;
  int    fails = 0;
  int    done_cnt = 0;
  int    cycles = 0;
  bit    stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vidx_agen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .idx_vec(idx_vec), .scale_sel(scale_sel), .disp(disp),
    .lane_mask(lane_mask), .wide_idx(wide_idx), .elem_fp64(elem_fp64),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_lane(out_lane), .out_fp64(out_fp64), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // consumer ready: always, or pseudo-random stalls
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [63:0] prev_addr;
  logic [3:0]  prev_lane;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
    if (rst_n) begin
      if (done) done_cnt++;
      if (prev_stall)
        chk(out_valid && out_addr == prev_addr && out_lane == prev_lane,
            "R6 stalled beat changed", {out_addr[59:0], out_lane}, {prev_addr[59:0], prev_lane});
      prev_stall = out_valid && !out_ready;
      prev_addr  = out_addr;
      prev_lane  = out_lane;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected beat", 64'(out_lane), 64'hFFFF);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(out_lane == e.lane, "R5 lane order", 64'(out_lane), 64'(e.lane));
          chk(out_addr == e.addr, "R4 address", out_addr, e.addr);
          chk(out_fp64 == e.fp, "R9 format tag", 64'(out_fp64), 64'(e.fp));
        end
      end
    end
  end

  // driver: pushes expectations computed from the requirements, then runs the job
  task automatic run_job(input logic [63:0] b, input logic [511:0] v, input logic [1:0] sc,
                         input logic [31:0] d, input logic [15:0] m, input logic w,
                         input logic fp, input bit poke);
    int lanes;
    int d0;
    bit seen;
    bit any;
    lanes = w ? 8 : 16;
    any = 1'b0;
    for (int i = 0; i < lanes; i++) begin
      if (m[i]) begin
        logic signed [63:0] ix;
        logic signed [63:0] ds;
        beat_t e;
        if (w) ix = $signed(v[64*i +: 64]);
        else   ix = $signed(v[32*i +: 32]);
        ds = $signed(d);
        e.addr = b + ix * (64'sd1 <<< sc) + ds;
        e.lane = 4'(i);
        e.fp   = fp;
        exp_q.push_back(e);
        any = 1'b1;
      end
    end
    d0 = done_cnt;
    @(negedge clk);
    base_addr = b; idx_vec = v; scale_sel = sc; disp = d;
    lane_mask = m; wide_idx = w; elem_fp64 = fp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble inputs right after capture
    base_addr = ~b; idx_vec = ~v; scale_sel = ~sc; disp = ~d; elem_fp64 = ~fp; wide_idx = ~w;
    chk(busy == any, "R8 busy after start", 64'(busy), 64'(any));
    seen = done;
    if (!any) chk(done == 1'b1, "R7 done on empty mask", 64'(done), 64'd1);
    for (int k = 0; k < 2000 && !seen; k++) begin
      if (poke && k == 2) start = 1'b1;
      if (poke && k == 3) start = 1'b0;
      @(negedge clk);
      seen = done;
    end
    start = 1'b0;
    chk(exp_q.size() == 0, "R5 beats missing at done", 64'(exp_q.size()), 64'd0);
    chk(busy == 1'b0, "R8 busy at done", 64'(busy), 64'd0);
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(done_cnt - d0 == 1, "R7 done pulse count", 64'(done_cnt - d0), 64'd1);
    chk(!out_valid, "R8 idle after done", 64'(out_valid), 64'd0);
  endtask

  initial begin
    logic [511:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs",
        {61'd0, out_valid, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: small positive 32-bit indexes, full mask, unit scale
    for (int i = 0; i < 16; i++) v[32*i +: 32] = 32'(i * 3 + 1);
    run_job(64'h0000_1000_0000_0000, v, 2'd0, 32'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0);

    // R2 + R4: negative 32-bit indexes, scale 8, negative displacement, stalls
    stall_mode = 1'b1;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = -32'(i * 1000 + 7);
    run_job(64'h0000_0000_0010_0000, v, 2'd3, -32'd64, 16'hA5C3, 1'b0, 1'b1, 1'b0);

    // R3 + R4: 64-bit indexes with wraparound, upper mask bits ignored
    for (int i = 0; i < 8; i++) v[64*i +: 64] = 64'hFFFF_FFF0_0000_0000 + 64'(i) * 64'h1234_5678_9ABC;
    run_job(64'hFFFF_FFFF_FFFF_F000, v, 2'd2, 32'h7FFF_FFFF, 16'hFF5A, 1'b1, 1'b1, 1'b0);

    // R7: empty mask, and wide mode with only upper mask bits (R3)
    run_job(64'h55, v, 2'd1, 32'd4, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_job(64'h55, v, 2'd1, 32'd4, 16'hFF00, 1'b1, 1'b0, 1'b0);

    // R8: start pulse during a running sequence is ignored
    for (int i = 0; i < 16; i++) v[32*i +: 32] = 32'(i) << 20;
    run_job(64'h8000_0000, v, 2'd1, 32'd16, 16'h7FFE, 1'b0, 1'b0, 1'b1);

    // R5 + R4: single top lane with base wrap
    stall_mode = 1'b0;
    run_job(64'hFFFF_FFFF_FFFF_FFFF, v, 2'd0, 32'd1, 16'h8000, 1'b0, 1'b1, 1'b0);

    // R6: all lanes in wide mode under heavy stalling
    stall_mode = 1'b1;
    for (int i = 0; i < 8; i++) v[64*i +: 64] = -64'(i + 1);
    run_job(64'h100, v, 2'd3, 32'd0, 16'h00FF, 1'b1, 1'b0, 1'b0);

    finish_run();
  end
endmodule